// File: doc/BRIEF.md
# Byte FIFO pair with status, interrupt and DMA-request logic

This block holds two byte queues of 32 entries each. One queue carries bytes out toward a serial engine and the other carries bytes in from it. A bus-facing side writes the outbound queue and reads the inbound queue. A serial-facing side pops the outbound queue and pushes the inbound queue. Both sides use single-cycle strobe ports. The serial shifter and the bus register decoder sit outside this block.

Around the queues the block keeps live fill levels and a set of sticky event flags. The flags cover thresholds, empty, full, overrun and underrun. Each flag is cleared by writing one to it. A per-flag enable mask folds the flags into one interrupt line. Two DMA request lines follow the fill levels against programmable thresholds, with opposite senses: the outbound request asks for more data while the queue is short, and the inbound request asks for draining while the queue is long. Four wake flags, each with its own enable, record level events. Each queue has a flush strobe that empties it and wipes that queue's status.

Top module: `fifo_event_hub`

## Requirements
- R1: Each queue returns bytes in the order they were accepted. Its level output (`txLevel`, `rxLevel`, 6 bits) counts the stored entries from 0 up to 32.
- R2: Read data (`serTxData`, `busRxData`) is presented in the cycle after the read strobe and is zero when the queue was empty. A write to a full queue is dropped, and a read from an empty queue leaves the contents and the level unchanged. A write is refused whenever the level is 32, even if a read happens in the same cycle.
- R3: Flag bit 0 (outbound threshold) sets one cycle after `txLevel < txThresh` becomes true. `txDmaReq` is high, in the same cycle, exactly while `txDmaEn` is 1 and `txLevel < txThresh`.
- R4: Flag bit 2 (inbound threshold) sets one cycle after `rxLevel > rxThresh` becomes true. `rxDmaReq` is high exactly while `rxDmaEn` is 1 and `rxLevel > rxThresh`.
- R5: Flag bit 1 sets one cycle after the outbound level reaches 0. Flag bit 3 sets one cycle after the inbound level reaches 32.
- R6: Flag bit 4 (outbound overrun) sets on a bus write to a full outbound queue. Flag bit 5 (outbound underrun) sets on a serial read of an empty outbound queue.
- R7: Flag bit 6 (inbound overrun) sets on a serial write to a full inbound queue. Flag bit 7 (inbound underrun) sets on a bus read of an empty inbound queue.
- R8: Flags stay set until a 1 in the matching `flagClr` bit clears them. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly while some flag bit and the matching `intEn` bit are both 1.
- R10: Dropping a DMA enable removes its request in the same cycle, with nothing held over.
- R11: A flush strobe empties its queue and beats a same-cycle write. It clears that queue's flags (outbound: bits 0,1,4,5; inbound: bits 2,3,6,7) and wake flags (outbound: bits 0,1; inbound: bits 2,3). The level change caused by a flush raises no flag.
- R12: Wake bits 0..3 (outbound threshold, outbound empty, inbound threshold, inbound full) set on the same level events as flag bits 0..3, but only while the matching `wakeEn` bit is 1. Each wake bit clears on a 1 in `wakeClr`. Clearing wake bits has no effect on the interrupt flags.
- R13: Out of reset all flags, wake bits, levels and read data are zero. A level condition that is already true when reset ends does not set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busTxWrEn | input | 1 | Bus write strobe into the outbound queue |
| busTxData | input | 8 | Bus write byte |
| busRxRdEn | input | 1 | Bus read strobe from the inbound queue |
| busRxData | output | 8 | Byte read by the bus, one cycle after the strobe |
| serTxRdEn | input | 1 | Serial read strobe from the outbound queue |
| serTxData | output | 8 | Byte read by the serial side, one cycle after the strobe |
| serRxWrEn | input | 1 | Serial write strobe into the inbound queue |
| serRxData | input | 8 | Serial write byte |
| txFlush | input | 1 | Empty the outbound queue and its status |
| rxFlush | input | 1 | Empty the inbound queue and its status |
| txThresh | input | 5 | Outbound threshold level |
| rxThresh | input | 5 | Inbound threshold level |
| txDmaEn | input | 1 | Outbound DMA request enable |
| rxDmaEn | input | 1 | Inbound DMA request enable |
| intEn | input | 8 | Interrupt enable per flag bit |
| flagClr | input | 8 | Write-one-to-clear strobes for the flags |
| wakeEn | input | 4 | Enable per wake bit |
| wakeClr | input | 4 | Write-one-to-clear strobes for the wake bits |
| txLevel | output | 6 | Outbound entry count |
| rxLevel | output | 6 | Inbound entry count |
| flags | output | 8 | Sticky event flags |
| irq | output | 1 | Interrupt: OR of enabled flags |
| txDmaReq | output | 1 | Outbound DMA request |
| rxDmaReq | output | 1 | Inbound DMA request |
| wakeFlags | output | 4 | Sticky wake bits |

## Verification
The bench builds the block with its default values: a depth of 32 and 8-bit data, so thresholds are 5 bits and levels 6 bits. At that size, filling either queue to 32 takes only a few dozen strobes. This lets the bench reach the full and overrun paths and the level value 32, which needs the sixth level bit. Threshold boundaries are probed where the level equals the threshold. The same-cycle collisions are exercised directly: a clear against an event, a flush against a write, and a DMA enable dropped while its request is high.

// File: rtl/fifo_hub_pkg.sv
package fifo_hub_pkg;

  localparam int FLAG_N = 8;
  localparam int WAKE_N = 4;

  // Flag bit positions (observed by software and the bench)
  localparam int FL_TX_THR   = 0;
  localparam int FL_TX_EMPTY = 1;
  localparam int FL_RX_THR   = 2;
  localparam int FL_RX_FULL  = 3;
  localparam int FL_TX_OVER  = 4;
  localparam int FL_TX_UNDER = 5;
  localparam int FL_RX_OVER  = 6;
  localparam int FL_RX_UNDER = 7;

  localparam logic [FLAG_N-1:0] TX_FLAG_MASK = (FLAG_N'(1) << FL_TX_THR)  | (FLAG_N'(1) << FL_TX_EMPTY) |
                                               (FLAG_N'(1) << FL_TX_OVER) | (FLAG_N'(1) << FL_TX_UNDER);
  localparam logic [FLAG_N-1:0] RX_FLAG_MASK = (FLAG_N'(1) << FL_RX_THR)  | (FLAG_N'(1) << FL_RX_FULL) |
                                               (FLAG_N'(1) << FL_RX_OVER) | (FLAG_N'(1) << FL_RX_UNDER);
  localparam logic [WAKE_N-1:0] TX_WAKE_MASK = 4'b0011;
  localparam logic [WAKE_N-1:0] RX_WAKE_MASK = 4'b1100;

  // Strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifoStrobes_t;

endpackage

// File: rtl/fifo_hub_ring.sv
module fifo_hub_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CW-1:0]     level
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      level  <= '0;
      rdData <= '0;
    end else if (flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      level  <= '0;
      rdData <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      rdData <= pop ? mem[rdPtr] : '0;
      level  <= level + CW'(push) - CW'(pop);
    end
  end

  // R1
  count_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !flush) |=> (level == $past(level) + CW'(1)));

  // R2
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (level < CW'(DEPTH)));

  // R2
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (level != '0));

endmodule

// File: rtl/fifo_hub_dp.sv
module fifo_hub_dp
  import fifo_hub_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] txWrData,
  input  logic [DATA_W-1:0] rxWrData,
  output logic [DATA_W-1:0] txRdData,
  output logic [DATA_W-1:0] rxRdData,
  output logic [CW-1:0]     txLevel,
  output logic [CW-1:0]     rxLevel
);

  localparam int NQ = 2;  // index 0: outbound, 1: inbound

  logic [NQ-1:0]     pushV;
  logic [NQ-1:0]     popV;
  logic [NQ-1:0]     flushV;
  logic [DATA_W-1:0] wrV  [NQ];
  logic [DATA_W-1:0] rdV  [NQ];
  logic [CW-1:0]     lvlV [NQ];

  assign pushV  = {strobes.rxPush,  strobes.txPush};
  assign popV   = {strobes.rxPop,   strobes.txPop};
  assign flushV = {strobes.rxFlush, strobes.txFlush};
  assign wrV[0] = txWrData;
  assign wrV[1] = rxWrData;

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    fifo_hub_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
      .clk    (clk),
      .rstN   (rstN),
      .push   (pushV[g]),
      .pop    (popV[g]),
      .flush  (flushV[g]),
      .wrData (wrV[g]),
      .rdData (rdV[g]),
      .level  (lvlV[g])
    );
  end

  assign txRdData = rdV[0];
  assign rxRdData = rdV[1];
  assign txLevel  = lvlV[0];
  assign rxLevel  = lvlV[1];

endmodule

// File: rtl/fifo_hub_ctl.sv
module fifo_hub_ctl
  import fifo_hub_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busTxWrEn,
  input  logic              busRxRdEn,
  input  logic              serTxRdEn,
  input  logic              serRxWrEn,
  input  logic              txFlush,
  input  logic              rxFlush,
  input  logic [AW-1:0]     txThresh,
  input  logic [AW-1:0]     rxThresh,
  input  logic              txDmaEn,
  input  logic              rxDmaEn,
  input  logic [FLAG_N-1:0] intEn,
  input  logic [FLAG_N-1:0] flagClr,
  input  logic [WAKE_N-1:0] wakeEn,
  input  logic [WAKE_N-1:0] wakeClr,
  input  logic [CW-1:0]     txLevel,
  input  logic [CW-1:0]     rxLevel,
  output fifoStrobes_t      strobes,
  output logic [FLAG_N-1:0] flags,
  output logic [WAKE_N-1:0] wakeFlags,
  output logic              irq,
  output logic              txDmaReq,
  output logic              rxDmaReq
);

  logic txFull, txEmpty, rxFull, rxEmpty;
  assign txFull  = (txLevel == CW'(DEPTH));
  assign txEmpty = (txLevel == '0);
  assign rxFull  = (rxLevel == CW'(DEPTH));
  assign rxEmpty = (rxLevel == '0);

  // Legal moves only; a flush overrides everything on its queue
  always_comb begin
    strobes.txPush  = busTxWrEn & ~txFull  & ~txFlush;
    strobes.txPop   = serTxRdEn & ~txEmpty & ~txFlush;
    strobes.txFlush = txFlush;
    strobes.rxPush  = serRxWrEn & ~rxFull  & ~rxFlush;
    strobes.rxPop   = busRxRdEn & ~rxEmpty & ~rxFlush;
    strobes.rxFlush = rxFlush;
  end

  // Level conditions (bit order matches wake bits and flag bits 0..3)
  logic txThrCond, rxThrCond;
  assign txThrCond = (txLevel < CW'(txThresh));
  assign rxThrCond = (rxLevel > CW'(rxThresh));

  logic [WAKE_N-1:0] levelCond;
  logic [WAKE_N-1:0] prevCond;
  logic [WAKE_N-1:0] levelRise;
  assign levelCond = {rxFull, rxThrCond, txEmpty, txThrCond};
  assign levelRise = levelCond & ~prevCond;

  // Flush parks the edge detector high so the emptied level raises nothing
  logic [WAKE_N-1:0] flushWake;
  assign flushWake = (txFlush ? TX_WAKE_MASK : '0) | (rxFlush ? RX_WAKE_MASK : '0);

  always_ff @(posedge clk) begin
    if (!rstN) prevCond <= '1;
    else       prevCond <= levelCond | flushWake;
  end

  // Access errors
  logic txOverEv, txUnderEv, rxOverEv, rxUnderEv;
  assign txOverEv  = busTxWrEn & txFull  & ~txFlush;
  assign txUnderEv = serTxRdEn & txEmpty & ~txFlush;
  assign rxOverEv  = serRxWrEn & rxFull  & ~rxFlush;
  assign rxUnderEv = busRxRdEn & rxEmpty & ~rxFlush;

  logic [FLAG_N-1:0] setEv;
  always_comb begin
    setEv = '0;
    setEv[FL_TX_THR]   = levelRise[0];
    setEv[FL_TX_EMPTY] = levelRise[1];
    setEv[FL_RX_THR]   = levelRise[2];
    setEv[FL_RX_FULL]  = levelRise[3];
    setEv[FL_TX_OVER]  = txOverEv;
    setEv[FL_TX_UNDER] = txUnderEv;
    setEv[FL_RX_OVER]  = rxOverEv;
    setEv[FL_RX_UNDER] = rxUnderEv;
  end

  logic [FLAG_N-1:0] flushFlag;
  assign flushFlag = (txFlush ? TX_FLAG_MASK : '0) | (rxFlush ? RX_FLAG_MASK : '0);

  logic [FLAG_N-1:0] keepMask;
  assign keepMask = flags & ~flagClr & ~flushFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags     <= '0;
      wakeFlags <= '0;
    end else begin
      flags     <= ((flags & ~flagClr) | setEv) & ~flushFlag;
      wakeFlags <= ((wakeFlags & ~wakeClr) | (levelRise & wakeEn)) & ~flushWake;
    end
  end

  assign irq      = |(flags & intEn);
  assign txDmaReq = txDmaEn & txThrCond;
  assign rxDmaReq = rxDmaEn & rxThrCond;

  // R6
  tx_over_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busTxWrEn && txLevel == CW'(DEPTH) && !txFlush) |=> flags[FL_TX_OVER]);

  // R7
  rx_under_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRxRdEn && rxLevel == '0 && !rxFlush) |=> flags[FL_RX_UNDER]);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & $past(keepMask)) == $past(keepMask)));

  // R12
  for (genvar w = 0; w < WAKE_N; w++) begin : g_wake_chk
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!wakeEn[w] && !wakeFlags[w]) |=> !wakeFlags[w]);
  end

endmodule

// File: rtl/fifo_event_hub.sv
module fifo_event_hub
  import fifo_hub_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busTxWrEn,
  input  logic [DATA_W-1:0] busTxData,
  input  logic              busRxRdEn,
  output logic [DATA_W-1:0] busRxData,
  input  logic              serTxRdEn,
  output logic [DATA_W-1:0] serTxData,
  input  logic              serRxWrEn,
  input  logic [DATA_W-1:0] serRxData,
  input  logic              txFlush,
  input  logic              rxFlush,
  input  logic [AW-1:0]     txThresh,
  input  logic [AW-1:0]     rxThresh,
  input  logic              txDmaEn,
  input  logic              rxDmaEn,
  input  logic [FLAG_N-1:0] intEn,
  input  logic [FLAG_N-1:0] flagClr,
  input  logic [WAKE_N-1:0] wakeEn,
  input  logic [WAKE_N-1:0] wakeClr,
  output logic [CW-1:0]     txLevel,
  output logic [CW-1:0]     rxLevel,
  output logic [FLAG_N-1:0] flags,
  output logic              irq,
  output logic              txDmaReq,
  output logic              rxDmaReq,
  output logic [WAKE_N-1:0] wakeFlags
);

  fifoStrobes_t strobes;

  fifo_hub_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .busTxWrEn (busTxWrEn),
    .busRxRdEn (busRxRdEn),
    .serTxRdEn (serTxRdEn),
    .serRxWrEn (serRxWrEn),
    .txFlush   (txFlush),
    .rxFlush   (rxFlush),
    .txThresh  (txThresh),
    .rxThresh  (rxThresh),
    .txDmaEn   (txDmaEn),
    .rxDmaEn   (rxDmaEn),
    .intEn     (intEn),
    .flagClr   (flagClr),
    .wakeEn    (wakeEn),
    .wakeClr   (wakeClr),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel),
    .strobes   (strobes),
    .flags     (flags),
    .wakeFlags (wakeFlags),
    .irq       (irq),
    .txDmaReq  (txDmaReq),
    .rxDmaReq  (rxDmaReq)
  );

  fifo_hub_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .txWrData (busTxData),
    .rxWrData (serRxData),
    .txRdData (serTxData),
    .rxRdData (busRxData),
    .txLevel  (txLevel),
    .rxLevel  (rxLevel)
  );

  // R11
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    txFlush |=> (txLevel == '0 && (flags & TX_FLAG_MASK) == '0));

  // R11
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxFlush |=> (rxLevel == '0 && (flags & RX_FLAG_MASK) == '0 && (wakeFlags & RX_WAKE_MASK) == '0));

endmodule

// File: tb/fifo_event_hub_tb_top.sv
`timescale 1ns/1ps
module fifo_event_hub_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busTxWrEn = 0, busRxRdEn = 0, serTxRdEn = 0, serRxWrEn = 0;
  logic [7:0] busTxData = 0, serRxData = 0;
  logic [7:0] busRxData, serTxData;
  logic       txFlush = 0, rxFlush = 0, txDmaEn = 0, rxDmaEn = 0;
  logic [4:0] txThresh = 0, rxThresh = 0;
  logic [7:0] intEn = 0, flagClr = 0;
  logic [3:0] wakeEn = 0, wakeClr = 0;
  logic [5:0] txLevel, rxLevel;
  logic [7:0] flags;
  logic       irq, txDmaReq, rxDmaReq;
  logic [3:0] wakeFlags;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fifo_event_hub dut_i (
    .clk(clk), .rstN(rstN),
    .busTxWrEn(busTxWrEn), .busTxData(busTxData),
    .busRxRdEn(busRxRdEn), .busRxData(busRxData),
    .serTxRdEn(serTxRdEn), .serTxData(serTxData),
    .serRxWrEn(serRxWrEn), .serRxData(serRxData),
    .txFlush(txFlush), .rxFlush(rxFlush),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .txDmaEn(txDmaEn), .rxDmaEn(rxDmaEn),
    .intEn(intEn), .flagClr(flagClr),
    .wakeEn(wakeEn), .wakeClr(wakeClr),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .flags(flags), .irq(irq),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .wakeFlags(wakeFlags)
  );

  // Outbound queue vectors: write or serial read, with expected byte and level
  typedef struct packed {
    logic       isRead;
    logic [7:0] data;
    logic [5:0] expLvl;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h11, 6'd1}, '{1'b0, 8'h22, 6'd2}, '{1'b0, 8'h33, 6'd3},
    '{1'b1, 8'h11, 6'd2}, '{1'b0, 8'h44, 6'd3}, '{1'b1, 8'h22, 6'd2},
    '{1'b1, 8'h33, 6'd1}, '{1'b1, 8'h44, 6'd0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] d);
    busTxWrEn = 1; busTxData = d; tick(); busTxWrEn = 0;
  endtask
  task automatic serRd();
    serTxRdEn = 1; tick(); serTxRdEn = 0;
  endtask
  task automatic serWr(input logic [7:0] d);
    serRxWrEn = 1; serRxData = d; tick(); serRxWrEn = 0;
  endtask
  task automatic busRd();
    busRxRdEn = 1; tick(); busRxRdEn = 0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick(); tick();
    // R13 reset state, empty condition already true at release
    chk("R13 flags", 32'(flags), 0);
    chk("R13 wake", 32'(wakeFlags), 0);
    chk("R13 irq", 32'(irq), 0);
    chk("R13 txLevel", 32'(txLevel), 0);
    chk("R13 rxLevel", 32'(rxLevel), 0);
    chk("R13 busRxData", 32'(busRxData), 0);

    // R1 / R2 vector walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRead) begin
        serRd();
        chk("R1 read order", 32'(serTxData), 32'(VECS[i].data));
      end else begin
        busWr(VECS[i].data);
      end
      chk("R1 level", 32'(txLevel), 32'(VECS[i].expLvl));
    end
    tick();
    chk("R5 empty flag", 32'(flags), 32'h02);

    flagClr = 8'h02; tick(); flagClr = 0;
    chk("R8 clear", 32'(flags), 0);

    serRd();
    chk("R2 empty read data", 32'(serTxData), 0);
    chk("R6 underrun", 32'(flags), 32'h20);
    chk("R2 empty read level", 32'(txLevel), 0);

    intEn = 8'h20; #1;
    chk("R9 irq on", 32'(irq), 1);
    intEn = 8'h01; #1;
    chk("R9 irq masked", 32'(irq), 0);

    txThresh = 5'd3; txDmaEn = 1; #1;
    chk("R3 dma low level", 32'(txDmaReq), 1);
    tick();
    chk("R3 thr flag", 32'(flags[0]), 1);
    chk("R9 irq thr", 32'(irq), 1);
    txDmaEn = 0; #1;
    chk("R10 dma drop", 32'(txDmaReq), 0);
    txDmaEn = 1;
    busWr(8'h50); busWr(8'h51);
    chk("R3 dma below", 32'(txDmaReq), 1);
    busWr(8'h52);
    chk("R3 dma at thr", 32'(txDmaReq), 0);

    // R8 event beats clear; R7 bus read of empty inbound
    flagClr = 8'hFF; busRxRdEn = 1; tick(); flagClr = 0; busRxRdEn = 0;
    chk("R8 set wins", 32'(flags), 32'h80);
    chk("R2 rx empty data", 32'(busRxData), 0);

    for (int i = 3; i < 32; i++) busWr(8'h50 + 8'(i));
    chk("R1 full level", 32'(txLevel), 32);
    busWr(8'hEE);
    chk("R6 overrun", 32'(flags[4]), 1);
    chk("R2 full write level", 32'(txLevel), 32);
    serRd();
    chk("R1 first out", 32'(serTxData), 32'h50);
    chk("R1 level after pop", 32'(txLevel), 31);

    txFlush = 1; busTxWrEn = 1; busTxData = 8'h77; tick(); txFlush = 0; busTxWrEn = 0;
    chk("R11 tx level", 32'(txLevel), 0);
    tick();
    chk("R11 tx flags", 32'(flags), 32'h80);

    wakeEn = 4'b0010;
    busWr(8'h99); serRd();
    chk("R11 fresh data", 32'(serTxData), 32'h99);
    tick();
    chk("R12 wake empty", 32'(wakeFlags), 32'h2);
    wakeClr = 4'h2; tick(); wakeClr = 0;
    chk("R12 wake clr", 32'(wakeFlags), 0);
    chk("R12 flag kept", 32'(flags[1]), 1);

    wakeEn = 4'b1000; rxThresh = 5'd2; rxDmaEn = 1;
    serWr(8'hA0); serWr(8'hA1);
    chk("R4 dma at thr", 32'(rxDmaReq), 0);
    serWr(8'hA2);
    chk("R4 dma above", 32'(rxDmaReq), 1);
    tick();
    chk("R4 thr flag", 32'(flags[2]), 1);
    chk("R12 wake gated", 32'(wakeFlags[2]), 0);
    for (int i = 3; i < 32; i++) serWr(8'hA0 + 8'(i));
    chk("R1 rx full level", 32'(rxLevel), 32);
    tick();
    chk("R5 full flag", 32'(flags[3]), 1);
    chk("R12 wake full", 32'(wakeFlags), 32'h8);
    serWr(8'hFF);
    chk("R7 overrun", 32'(flags[6]), 1);
    chk("R2 rx full level", 32'(rxLevel), 32);
    busRd();
    chk("R1 rx first out", 32'(busRxData), 32'hA0);

    rxFlush = 1; tick(); rxFlush = 0;
    chk("R11 rx level", 32'(rxLevel), 0);
    chk("R11 rx flags", 32'(flags & 8'hCC), 0);
    chk("R11 rx wake", 32'(wakeFlags), 0);
    chk("R4 dma after flush", 32'(rxDmaReq), 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule